// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Handshake Flow Control

This block is a host-side asynchronous serial port. The host writes bytes into a 16-entry transmit queue. A transmitter serialises each byte as one start bit, 5 to 8 data bits sent LSB first, an optional parity bit, and 1, 1.5 or 2 stop bits. A receiver on the other line rebuilds characters and stores each one in a 16-entry receive queue. Every receive entry carries three flags: parity error, framing error and break. The host sees the head entry on the read port and removes it with a one-cycle read strobe.

A programmable divider sets the rate as a tick at sixteen times the bit rate. Both directions use this tick. Two optional handshake lines give hardware flow control, and each direction can be enabled on its own. With transmit control on, the transmitter holds off new characters while the peer signals not-ready. With receive control on, the block signals not-ready to its peer when its receive queue is nearly full. With both controls off, the handshake input is ignored and the port works on its two data lines alone.

Top module: `hs_uart`

## Requirements
- R1: Each queue holds 16 entries. `tx_full` is high while 16 bytes wait. A write while the transmit queue is full is discarded.
- R2: The line idles high. A character is one low start bit, then the data bits LSB first. `cfg_dbits` codes 0, 1, 2, 3 select 5, 6, 7, 8 data bits. Unused upper data bits are sent as nothing and received as 0.
- R3: With `cfg_par_en` set, a parity bit follows the data. `cfg_par_kind` selects its value: 0 odd (the total count of ones is odd), 1 even, 2 always 0, 3 always 1.
- R4: `cfg_stop` codes 0, 1, 2 select stop lengths of 16, 24 and 32 ticks (1, 1.5 and 2 bits). The code 3 acts as 2.
- R5: A tick occurs every `cfg_div`+1 clock cycles. Each bit lasts 16 ticks.
- R6: The receiver checks the start bit again at its middle (8 ticks after the falling edge) and drops a low pulse that has already ended. It samples each later bit 16 ticks after the one before.
- R7: A received entry has its parity error flag set when the parity bit differs from the one R3 defines. It has its framing error flag set when the first stop bit is sampled low.
- R8: A frame whose start, data, parity and first stop samples are all low yields exactly one entry: data 0, break flag 1, the other flags 0. After a break or framing error, no new start is looked for until the line has been high.
- R9: With `cfg_txfc_en` set and `hs_in_n` high, no new character starts. A character already on the line completes. With `cfg_txfc_en` clear, `hs_in_n` has no effect.
- R10: With `cfg_rxfc_en` set, `hs_out_n` is high while the receive queue holds 14 or more entries and low otherwise. With it clear, `hs_out_n` stays low.
- R11: After reset, `txd` is high, `hs_out_n` is low, both queues are empty and `tx_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Tick period minus one, in clocks |
| cfg_dbits | input | 2 | Data bit count code (5 + code) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_kind | input | 2 | Parity rule: odd, even, fixed 0, fixed 1 |
| cfg_stop | input | 2 | Stop length code |
| cfg_txfc_en | input | 1 | Transmit flow control enable |
| cfg_rxfc_en | input | 1 | Receive flow control enable |
| tx_wr | input | 1 | Write strobe for the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_busy | output | 1 | Transmit queue not empty or character on the line |
| rx_rd | input | 1 | Removes the head receive entry |
| rx_rdata | output | 8 | Head entry data |
| rx_brk | output | 1 | Head entry break flag |
| rx_ferr | output | 1 | Head entry framing error flag |
| rx_perr | output | 1 | Head entry parity error flag |
| rx_empty | output | 1 | Receive queue empty |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| hs_in_n | input | 1 | Peer ready, active low |
| hs_out_n | output | 1 | Local ready, active low |

## Verification
Two events can coincide. The peer's ready line can drop while a character is still being sent, and the receive queue's level can cross 14 while the host is reading. The bench provokes the first by raising `hs_in_n` a few cycles after the start bit appears on `txd`. It then requires that exactly that one character arrives in the scoreboard and that the line stays idle until `hs_in_n` falls again. For the second, the bench fills the receive queue to 14 and then lets the host drain it. It judges `hs_out_n` at each stage, including when `cfg_rxfc_en` is toggled while the queue is full.

// File: rtl/hs_uart_pkg.sv
package hs_uart_pkg;

  localparam int CHAR_W = 8;

  localparam logic [1:0] PK_ODD   = 2'd0;
  localparam logic [1:0] PK_EVEN  = 2'd1;
  localparam logic [1:0] PK_ZERO  = 2'd2;
  localparam logic [1:0] PK_ONE   = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI
  } ser_state_t;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  // keep only the low 5+dbits bits
  function automatic logic [CHAR_W-1:0] keep_bits(input logic [CHAR_W-1:0] d,
                                                  input logic [1:0] dbits);
    return d & (8'hFF >> (3'd3 - {1'b0, dbits}));
  endfunction

  function automatic logic par_calc(input logic [CHAR_W-1:0] d, input logic [1:0] kind);
    logic r;
    unique case (kind)
      PK_ODD:  r = ~^d;
      PK_EVEN: r = ^d;
      PK_ZERO: r = 1'b0;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hs_uart_baud.sv
module hs_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == '0);
    cnt_d = tick ? div : cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: tick spacing follows the divider
  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/hs_uart_fifo.sv
module hs_uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
    wp_d    = do_push ? step(wp_q) : wp_q;
    rp_d    = do_pop  ? step(rp_q) : rp_q;
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_full_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/hs_uart_tx.sv
module hs_uart_tx
  import hs_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        cfg_dbits,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_kind,
  input  logic [1:0]        cfg_stop,
  input  logic              fc_en,
  input  logic              hs_in_s,
  input  logic              q_empty,
  input  logic [CHAR_W-1:0] q_data,
  output logic              q_pop,
  output logic              txd,
  output logic              active
);
  ser_state_t        st_q, st_d;
  logic [5:0]        tc_q, tc_d, last;
  logic [2:0]        bi_q, bi_d;
  logic [CHAR_W-1:0] sh_q, sh_d, pick;
  logic              pb_q, pb_d, line_d, txd_q;
  logic [5:0]        stop_last;

  always_comb begin
    unique case (cfg_stop)
      2'd0:    stop_last = 6'd15;
      2'd1:    stop_last = 6'd23;
      default: stop_last = 6'd31;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    tc_d  = tc_q;
    bi_d  = bi_q;
    sh_d  = sh_q;
    pb_d  = pb_q;
    q_pop = 1'b0;
    pick  = keep_bits(q_data, cfg_dbits);
    last  = (st_q == S_STOP) ? stop_last : 6'd15;
    if (st_q == S_IDLE) begin
      if (!q_empty && !(fc_en && hs_in_s)) begin
        q_pop = 1'b1;
        sh_d  = pick;
        pb_d  = par_calc(pick, cfg_par_kind);
        st_d  = S_START;
        tc_d  = '0;
        bi_d  = '0;
      end
    end else if (tick) begin
      if (tc_q == last) begin
        tc_d = '0;
        unique case (st_q)
          S_START: st_d = S_DATA;
          S_DATA: begin
            sh_d = sh_q >> 1;
            if (bi_q == 3'd4 + {1'b0, cfg_dbits}) st_d = cfg_par_en ? S_PAR : S_STOP;
            else                                 bi_d = bi_q + 3'd1;
          end
          S_PAR:   st_d = S_STOP;
          default: st_d = S_IDLE;
        endcase
      end else begin
        tc_d = tc_q + 6'd1;
      end
    end
    unique case (st_d)
      S_START: line_d = 1'b0;
      S_DATA:  line_d = sh_d[0];
      S_PAR:   line_d = pb_d;
      default: line_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      tc_q  <= '0;
      bi_q  <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
      txd_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      tc_q  <= tc_d;
      bi_q  <= bi_d;
      sh_q  <= sh_d;
      pb_q  <= pb_d;
      txd_q <= line_d;
    end
  end

  assign txd    = txd_q;
  assign active = (st_q != S_IDLE);

  assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && fc_en && hs_in_s) |=> (st_q == S_IDLE));
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> txd_q);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_START) |-> !txd_q);
endmodule

// File: rtl/hs_uart_rx.sv
module hs_uart_rx
  import hs_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic [1:0] cfg_dbits,
  input  logic       cfg_par_en,
  input  logic [1:0] cfg_par_kind,
  output logic       push,
  output rx_entry_t  ent
);
  ser_state_t        st_q, st_d;
  logic [5:0]        tc_q, tc_d;
  logic [2:0]        bi_q, bi_d;
  logic [CHAR_W-1:0] sh_q, sh_d, got;
  logic              pr_q, pr_d, seen_q, seen_d;

  always_comb begin
    st_d   = st_q;
    tc_d   = tc_q;
    bi_d   = bi_q;
    sh_d   = sh_q;
    pr_d   = pr_q;
    seen_d = seen_q;
    push   = 1'b0;
    got    = CHAR_W'(sh_q >> (3'd3 - {1'b0, cfg_dbits}));
    ent.data = got;
    ent.brk  = 1'b0;
    ent.ferr = !rxd_s;
    ent.perr = cfg_par_en && (pr_q != par_calc(got, cfg_par_kind));
    unique case (st_q)
      S_IDLE: if (tick && !rxd_s) begin
        st_d = S_START;
        tc_d = '0;
      end
      S_START: if (tick) begin
        if (tc_q == 6'd7) begin
          if (!rxd_s) begin
            st_d   = S_DATA;
            tc_d   = '0;
            bi_d   = '0;
            seen_d = 1'b0;
          end else begin
            st_d = S_IDLE;
          end
        end else tc_d = tc_q + 6'd1;
      end
      S_DATA: if (tick) begin
        if (tc_q == 6'd15) begin
          tc_d   = '0;
          sh_d   = {rxd_s, sh_q[CHAR_W-1:1]};
          seen_d = seen_q | rxd_s;
          if (bi_q == 3'd4 + {1'b0, cfg_dbits}) st_d = cfg_par_en ? S_PAR : S_STOP;
          else                                 bi_d = bi_q + 3'd1;
        end else tc_d = tc_q + 6'd1;
      end
      S_PAR: if (tick) begin
        if (tc_q == 6'd15) begin
          tc_d   = '0;
          pr_d   = rxd_s;
          seen_d = seen_q | rxd_s;
          st_d   = S_STOP;
        end else tc_d = tc_q + 6'd1;
      end
      S_STOP: if (tick) begin
        if (tc_q == 6'd15) begin
          tc_d = '0;
          push = 1'b1;
          if (!seen_q && !rxd_s) begin
            ent.data = '0;
            ent.brk  = 1'b1;
            ent.ferr = 1'b0;
            ent.perr = 1'b0;
            st_d     = S_WAITHI;
          end else begin
            st_d = rxd_s ? S_IDLE : S_WAITHI;
          end
        end else tc_d = tc_q + 6'd1;
      end
      default: if (rxd_s) st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tc_q   <= '0;
      bi_q   <= '0;
      sh_q   <= '0;
      pr_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tc_q   <= tc_d;
      bi_q   <= bi_d;
      sh_q   <= sh_d;
      pr_q   <= pr_d;
      seen_q <= seen_d;
    end
  end

  assert_glitch_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_START && tick && tc_q == 6'd7 && rxd_s) |=> (st_q == S_IDLE));
  assert_break_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && ent.brk) |=> (st_q == S_WAITHI && !push));
  assert_waithi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAITHI && !rxd_s) |=> (st_q == S_WAITHI));
endmodule

// File: rtl/hs_uart.sv
module hs_uart
  import hs_uart_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int HOLD_GAP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_dbits,
  input  logic             cfg_par_en,
  input  logic [1:0]       cfg_par_kind,
  input  logic [1:0]       cfg_stop,
  input  logic             cfg_txfc_en,
  input  logic             cfg_rxfc_en,
  input  logic             tx_wr,
  input  logic [7:0]       tx_wdata,
  output logic             tx_full,
  output logic             tx_busy,
  input  logic             rx_rd,
  output logic [7:0]       rx_rdata,
  output logic             rx_brk,
  output logic             rx_ferr,
  output logic             rx_perr,
  output logic             rx_empty,
  output logic             txd,
  input  logic             rxd,
  input  logic             hs_in_n,
  output logic             hs_out_n
);
  localparam int CW       = $clog2(FIFO_DEPTH + 1);
  localparam int HOLD_LVL = FIFO_DEPTH - HOLD_GAP;
  localparam int ENT_W    = $bits(rx_entry_t);

  logic            tick;
  logic [1:0]      rxd_sync, hs_sync;
  logic            txq_empty, txq_pop, tx_act;
  logic [7:0]      txq_data;
  logic [CW-1:0]   txq_cnt, rxq_cnt;
  logic            rx_push, hs_out_d, hs_out_q;
  rx_entry_t       rx_ent, rx_head;
  logic [ENT_W-1:0] rx_head_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_sync <= 2'b11;
      hs_sync  <= 2'b11;
      hs_out_q <= 1'b0;
    end else begin
      rxd_sync <= {rxd_sync[0], rxd};
      hs_sync  <= {hs_sync[0], hs_in_n};
      hs_out_q <= hs_out_d;
    end
  end

  always_comb hs_out_d = cfg_rxfc_en && (rxq_cnt >= CW'(HOLD_LVL));

  hs_uart_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  hs_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) txq_i (
    .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_wdata), .pop(txq_pop),
    .rdata(txq_data), .full(tx_full), .empty(txq_empty), .count(txq_cnt)
  );

  hs_uart_tx tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_dbits(cfg_dbits),
    .cfg_par_en(cfg_par_en), .cfg_par_kind(cfg_par_kind), .cfg_stop(cfg_stop),
    .fc_en(cfg_txfc_en), .hs_in_s(hs_sync[1]), .q_empty(txq_empty),
    .q_data(txq_data), .q_pop(txq_pop), .txd(txd), .active(tx_act)
  );

  hs_uart_rx rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rxd_sync[1]),
    .cfg_dbits(cfg_dbits), .cfg_par_en(cfg_par_en), .cfg_par_kind(cfg_par_kind),
    .push(rx_push), .ent(rx_ent)
  );

  hs_uart_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) rxq_i (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_ent), .pop(rx_rd),
    .rdata(rx_head_raw), .full(), .empty(rx_empty), .count(rxq_cnt)
  );

  assign rx_head  = rx_entry_t'(rx_head_raw);
  assign rx_rdata = rx_head.data;
  assign rx_brk   = rx_head.brk;
  assign rx_ferr  = rx_head.ferr;
  assign rx_perr  = rx_head.perr;
  assign tx_busy  = tx_act || !txq_empty;
  assign hs_out_n = hs_out_q;

  assert_rts_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rxfc_en && rxq_cnt >= CW'(HOLD_LVL)) |=> hs_out_n);
  assert_rts_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rxfc_en || rxq_cnt < CW'(HOLD_LVL)) |=> !hs_out_n);
endmodule

// File: tb/hs_uart_tb_top.sv
module hs_uart_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [15:0] cfg_div;
  logic [1:0]  cfg_dbits, cfg_par_kind, cfg_stop;
  logic        cfg_par_en, cfg_txfc_en, cfg_rxfc_en;
  logic        tx_wr, rx_rd, tx_full, tx_busy;
  logic [7:0]  tx_wdata, rx_rdata;
  logic        rx_brk, rx_ferr, rx_perr, rx_empty;
  logic        txd, rxd_w, drv_rxd, lb, hs_in_n, hs_out_n;

  assign rxd_w = lb ? txd : drv_rxd;

  hs_uart dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_dbits(cfg_dbits),
    .cfg_par_en(cfg_par_en), .cfg_par_kind(cfg_par_kind), .cfg_stop(cfg_stop),
    .cfg_txfc_en(cfg_txfc_en), .cfg_rxfc_en(cfg_rxfc_en), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_busy(tx_busy), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .rx_brk(rx_brk), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .rx_empty(rx_empty), .txd(txd), .rxd(rxd_w), .hs_in_n(hs_in_n),
    .hs_out_n(hs_out_n)
  );

  int          checks = 0;
  int          errors = 0;
  logic [10:0] exp_q[$];
  bit          mon_en = 1'b0;
  string       cur_req = "R2";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] msk(input logic [7:0] d, input logic [1:0] code);
    return d & ((8'h01 << (5 + code)) - 8'h01);
  endfunction

  function automatic logic pbit(input logic [7:0] d, input logic [1:0] kind);
    case (kind)
      2'd0: return ~^d;
      2'd1: return ^d;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int bt();
    return 16 * (int'(cfg_div) + 1);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rx_rd) rx_rd <= 1'b0;
    else if (mon_en && rst_n && !rx_empty) begin
      if (exp_q.size() == 0)
        chk(1'b0, cur_req, "unexpected entry", {21'd0, rx_brk, rx_ferr, rx_perr, rx_rdata}, 0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk({rx_brk, rx_ferr, rx_perr, rx_rdata} == e, cur_req, "rx entry",
            {21'd0, rx_brk, rx_ferr, rx_perr, rx_rdata}, {21'd0, e});
      end
      rx_rd <= 1'b1;
    end
  end

  task automatic host_wr(input logic [7:0] d, input bit expect_it);
    @(negedge clk);
    tx_wr = 1'b1;
    tx_wdata = d;
    if (expect_it) exp_q.push_back({3'b000, msk(d, cfg_dbits)});
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || tx_busy || !rx_empty) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3 * bt()) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit pv, input bit stopv);
    drv_rxd = 1'b0;
    repeat (bt()) @(negedge clk);
    for (int i = 0; i < 5 + int'(cfg_dbits); i++) begin
      drv_rxd = d[i];
      repeat (bt()) @(negedge clk);
    end
    if (cfg_par_en) begin
      drv_rxd = pv;
      repeat (bt()) @(negedge clk);
    end
    drv_rxd = stopv;
    repeat (bt()) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (bt()) @(negedge clk);
  endtask

  task automatic measure(input logic [7:0] d);
    int dur = 0;
    int expd;
    int stp;
    stp  = (cfg_stop == 2'd0) ? 16 : (cfg_stop == 2'd1) ? 24 : 32;
    expd = (1 + 5 + int'(cfg_dbits) + int'(cfg_par_en)) * bt() + stp * (int'(cfg_div) + 1);
    host_wr(d, 1'b1);
    while (tx_busy) begin
      dur++;
      @(negedge clk);
    end
    chk(dur >= expd - 6 && dur <= expd + 6, "R4", "frame length", dur, expd);
  endtask

  logic [1:0] c_db[5] = '{2'd3, 2'd0, 2'd2, 2'd1, 2'd3};
  logic       c_pe[5] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  logic [1:0] c_pk[5] = '{2'd0, 2'd0, 2'd1, 2'd3, 2'd2};
  logic [1:0] c_st[5] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd2};
  logic [15:0] c_dv[5] = '{16'd3, 16'd3, 16'd5, 16'd1, 16'd3};

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_div = 16'd3; cfg_dbits = 2'd3; cfg_par_en = 1'b0;
    cfg_par_kind = 2'd0; cfg_stop = 2'd0; cfg_txfc_en = 1'b0; cfg_rxfc_en = 1'b0;
    tx_wr = 1'b0; tx_wdata = '0; rx_rd = 1'b0; lb = 1'b1; drv_rxd = 1'b1; hs_in_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk(txd == 1'b1, "R11", "txd idle", txd, 1);
    chk(rx_empty == 1'b1, "R11", "rx empty", rx_empty, 1);
    chk(tx_full == 1'b0 && tx_busy == 1'b0, "R11", "tx queue idle", {tx_full, tx_busy}, 0);
    chk(hs_out_n == 1'b0, "R11", "hs_out_n ready", hs_out_n, 0);
    mon_en = 1'b1;

    // loopback over formats, hs_in_n high but flow control off (R9 ignored)
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cfg_dbits = c_db[k]; cfg_par_en = c_pe[k]; cfg_par_kind = c_pk[k];
      cfg_stop = c_st[k]; cfg_div = c_dv[k];
      cur_req = "R2";
      repeat (2 * bt()) @(negedge clk);
      measure(8'hC3);
      host_wr(8'hA5, 1'b1);
      host_wr(8'h3C, 1'b1);
      host_wr(8'hFF, 1'b1);
      host_wr(8'h00, 1'b1);
      drain();
      chk(exp_q.size() == 0, "R5", "all loopback frames seen", exp_q.size(), 0);
    end

    // R3 transmitted parity bit, 8 data bits even parity, data 0x07
    @(negedge clk);
    cfg_dbits = 2'd3; cfg_par_en = 1'b1; cfg_par_kind = 2'd1; cfg_stop = 2'd0; cfg_div = 16'd3;
    cur_req = "R3";
    host_wr(8'h07, 1'b1);
    while (txd) @(negedge clk);
    repeat (bt() + bt() / 2) @(negedge clk);
    chk(txd == 1'b1, "R2", "data bit0 lsb first", txd, 1);
    repeat (8 * bt()) @(negedge clk);
    chk(txd == 1'b1, "R3", "even parity bit", txd, 1);
    drain();

    // receiver tests from bench driver
    lb = 1'b0;
    cfg_par_kind = 2'd0;
    cur_req = "R7";
    exp_q.push_back({3'b000, 8'h01});
    send_frame(8'h01, 1'b0, 1'b1);
    exp_q.push_back({3'b001, 8'h01});
    send_frame(8'h01, 1'b1, 1'b1);
    cfg_par_kind = 2'd3;
    exp_q.push_back({3'b000, 8'h00});
    send_frame(8'h00, 1'b1, 1'b1);
    exp_q.push_back({3'b001, 8'h00});
    send_frame(8'h00, 1'b0, 1'b1);
    cfg_par_kind = 2'd1;
    exp_q.push_back({3'b010, 8'h55});
    send_frame(8'h55, 1'b0, 1'b0);
    drain();
    chk(exp_q.size() == 0, "R7", "error entries seen", exp_q.size(), 0);

    // R8 break: line low for more than a frame
    cur_req = "R8";
    exp_q.push_back({3'b100, 8'h00});
    drv_rxd = 1'b0;
    repeat (14 * bt()) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (2 * bt()) @(negedge clk);
    exp_q.push_back({3'b000, 8'h96});
    send_frame(8'h96, 1'b0, 1'b1);
    drain();
    chk(exp_q.size() == 0 && rx_empty, "R8", "one break entry then recovery", exp_q.size(), 0);

    // R6 glitch shorter than half a bit
    cur_req = "R6";
    drv_rxd = 1'b0;
    repeat (bt() / 4) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (14 * bt()) @(negedge clk);
    chk(rx_empty == 1'b1, "R6", "glitch rejected", rx_empty, 1);

    // R9 / R1 transmit flow control
    lb = 1'b1;
    cfg_par_en = 1'b0;
    cfg_txfc_en = 1'b1;
    hs_in_n = 1'b1;
    cur_req = "R9";
    for (int i = 0; i < 16; i++) host_wr(8'h10 + 8'(i), 1'b1);
    host_wr(8'hEE, 1'b0);
    begin
      bit stayed = 1'b1;
      repeat (300) begin
        @(negedge clk);
        if (!txd) stayed = 1'b0;
      end
      chk(stayed, "R9", "no start while peer not ready", {31'd0, stayed}, 1);
    end
    chk(tx_full == 1'b1, "R1", "tx queue full at 16", tx_full, 1);
    hs_in_n = 1'b0;
    while (txd) @(negedge clk);
    repeat (10) @(negedge clk);
    hs_in_n = 1'b1;
    repeat (16 * bt()) @(negedge clk);
    chk(exp_q.size() == 15, "R9", "only in-progress char completed", exp_q.size(), 15);
    chk(txd == 1'b1 && tx_full == 1'b0, "R9", "line idle after hold", {txd, tx_full}, 2);
    hs_in_n = 1'b0;
    drain();
    chk(exp_q.size() == 0 && rx_empty, "R1", "write while full dropped", exp_q.size(), 0);
    cfg_txfc_en = 1'b0;

    // R10 receive flow control
    lb = 1'b0;
    mon_en = 1'b0;
    cfg_rxfc_en = 1'b1;
    cur_req = "R10";
    for (int i = 0; i < 13; i++) begin
      exp_q.push_back({3'b000, 8'h40 + 8'(i)});
      send_frame(8'h40 + 8'(i), 1'b0, 1'b1);
    end
    chk(hs_out_n == 1'b0, "R10", "ready at 13 entries", hs_out_n, 0);
    exp_q.push_back({3'b000, 8'h4D});
    send_frame(8'h4D, 1'b0, 1'b1);
    chk(hs_out_n == 1'b1, "R10", "not ready at 14 entries", hs_out_n, 1);
    @(negedge clk);
    cfg_rxfc_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(hs_out_n == 1'b0, "R10", "disabled keeps ready", hs_out_n, 0);
    cfg_rxfc_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(hs_out_n == 1'b1, "R10", "re-enabled at 14", hs_out_n, 1);
    mon_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(hs_out_n == 1'b0, "R10", "ready below 14", hs_out_n, 0);
    drain();
    chk(exp_q.size() == 0, "R1", "all rx entries drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule